// File: doc/BRIEF.md
# Debugger Authentication Gate

This block decides whether an external debugger may reach the processor. The debug module forwards reads and writes of a 32-bit authentication data register to it. The block keeps one authorization bit, reports it on an `authenticated` status output together with a `auth_busy` output, and composes the status-register bits the debugger polls.

While the debugger is not authorized, a gate stage sits between the debug transport and the debug module. It blocks halt requests, resume requests and every debug-module register access except those to the authentication data register and the status register. Abstract commands are reached through a debug-module register, so they are blocked by address as well.

A build-time parameter selects either the real single-bit authenticator or a bypass variant. In the bypass variant access is always granted, and the data register and the busy flag are tied to zero. A second parameter selects the older debug specification version code reported in the status word.

Top module: `dbg_auth_gate`

## Requirements
- R1: After system reset (`rst_n` low) with authentication built in, `authenticated` is 0.
- R2: With authentication built in, a cycle with `auth_wr` high, `dm_rst` low and `auth_wdata` bit 0 set makes `authenticated` 1 from the next clock edge on. Bits 31:1 of the written value have no effect.
- R3: With authentication built in, a write with `auth_wdata` bit 0 clear makes `authenticated` 0 from the next clock edge on.
- R4: While `auth_rd` is high, `auth_rdata` equals `{31'b0, authenticated}`. While `auth_rd` is low, `auth_rdata` is 0.
- R5: `dm_rst` high at a clock edge clears `authenticated` at that edge. This takes priority over a write in the same cycle.
- R6: `auth_busy` is 0 at all times, because the single-bit mechanism completes every access in one cycle.
- R7: While `authenticated` is 0, `halt_req_o` and `resume_req_o` are 0, and `dmi_pass` is 1 only when `dmi_req` is 1 and `dmi_addr` is the authentication data address (default 7'h30) or the status address (default 7'h11). While `authenticated` is 1, the three outputs follow `dmi_req`, `halt_req_i` and `resume_req_i`.
- R8: `stat_word` bit 7 is `authenticated`, bit 6 is `auth_busy`, bits 3:0 are 4'b0011 by default or 4'b0010 when `LEGACY` is 1, and all other bits are 0.
- R9: With `AUTH_EN` = 0, `authenticated` is 1, `auth_busy` is 0 and `auth_rdata` is 0 at all times. Writes and `dm_rst` have no effect, and the gate passes everything.
- R10: With authentication built in, in a cycle with `auth_wr` and `dm_rst` both low, `authenticated` keeps its value. A read strobe does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| dm_rst | input | 1 | Synchronous debug-module reset |
| auth_wr | input | 1 | Write strobe for the authentication data register |
| auth_rd | input | 1 | Read strobe for the authentication data register |
| auth_wdata | input | 32 | Write data |
| auth_rdata | output | 32 | Read data |
| authenticated | output | 1 | Debugger is authorized |
| auth_busy | output | 1 | Authenticator is busy |
| stat_word | output | 32 | Authentication and version bits of the status register |
| dmi_req | input | 1 | Debug-module register access request |
| dmi_addr | input | 7 | Debug-module register address |
| dmi_pass | output | 1 | Access request let through to the debug module |
| halt_req_i | input | 1 | Halt request from the debugger |
| halt_req_o | output | 1 | Gated halt request |
| resume_req_i | input | 1 | Resume request from the debugger |
| resume_req_o | output | 1 | Gated resume request |

## Verification
A wrong authorization bit shows at the ports within one clock edge of the write or reset that should have set it. It appears on `authenticated`, on bit 7 of `stat_word`, on bit 0 of `auth_rdata` during a read, and on the gate outputs, which pass or block requests in the same cycle. A status word with a stray bit or the wrong version code shows on `stat_word` at any time. Because each write leaves its effect after exactly one edge, a wrongly kept or lost write is visible at the first sample after that edge.

// File: rtl/dbg_auth_pkg.sv
package dbg_auth_pkg;
   localparam int unsigned AUTH_DATA_W   = 32;
   localparam int unsigned FLAG_BIT      = 0;
   localparam int unsigned STAT_AUTH_POS = 7;
   localparam int unsigned STAT_BUSY_POS = 6;
   localparam int unsigned VER_W         = 4;
   localparam logic [VER_W-1:0] VER_CUR  = 4'b0011;
   localparam logic [VER_W-1:0] VER_OLD  = 4'b0010;

   typedef enum logic [1:0] {
      ROUTE_BLOCK = 2'd0,
      ROUTE_AUTH  = 2'd1,
      ROUTE_STAT  = 2'd2,
      ROUTE_OPEN  = 2'd3
   } route_e;
endpackage

// File: rtl/dbg_auth_store.sv
module dbg_auth_store #(
   parameter bit          AUTH_EN = 1'b1,
   parameter int unsigned DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dm_rst,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              flag,
   output logic              busy
);
   import dbg_auth_pkg::*;

   generate
      if (AUTH_EN) begin : g_real
         logic flag_q;
         logic unused_hi;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q <= 1'b0;
            end else if (dm_rst) begin
               flag_q <= 1'b0;
            end else if (wr) begin
               flag_q <= wdata[FLAG_BIT];
            end
         end

         assign unused_hi = ^wdata;
         assign flag      = flag_q;
         assign busy      = 1'b0;
         always_comb begin
            rdata           = '0;
            rdata[FLAG_BIT] = rd & flag_q;
         end
      end else begin : g_bypass
         logic unused_in;
         assign unused_in = ^{clk, rst_n, dm_rst, wr, rd, wdata};
         assign flag      = 1'b1;
         assign busy      = 1'b0;
         assign rdata     = '0;
      end
   endgenerate
endmodule

// File: rtl/dbg_auth_stat.sv
module dbg_auth_stat #(
   parameter bit          LEGACY = 1'b0,
   parameter int unsigned DATA_W = 32
) (
   input  logic              flag,
   input  logic              busy,
   output logic [DATA_W-1:0] word
);
   import dbg_auth_pkg::*;

   localparam logic [VER_W-1:0] VER_SEL = LEGACY ? VER_OLD : VER_CUR;

   always_comb begin
      word                = '0;
      word[VER_W-1:0]     = VER_SEL;
      word[STAT_BUSY_POS] = busy;
      word[STAT_AUTH_POS] = flag;
   end
endmodule

// File: rtl/dbg_auth_filter.sv
module dbg_auth_filter #(
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned AUTH_ADDR = 7'h30,
   parameter int unsigned STAT_ADDR = 7'h11
) (
   input  logic              flag,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   input  logic              halt_i,
   input  logic              resume_i,
   output logic              pass,
   output logic              halt_o,
   output logic              resume_o
);
   import dbg_auth_pkg::*;

   localparam logic [ADDR_W-1:0] A_AUTH = ADDR_W'(AUTH_ADDR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

   route_e route;

   always_comb begin
      if (flag)                route = ROUTE_OPEN;
      else if (addr == A_AUTH) route = ROUTE_AUTH;
      else if (addr == A_STAT) route = ROUTE_STAT;
      else                     route = ROUTE_BLOCK;
   end

   assign pass     = req & (route != ROUTE_BLOCK);
   assign halt_o   = halt_i & (route == ROUTE_OPEN);
   assign resume_o = resume_i & (route == ROUTE_OPEN);
endmodule

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate #(
   parameter bit          AUTH_EN   = 1'b1,
   parameter bit          LEGACY    = 1'b0,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned AUTH_ADDR = 7'h30,
   parameter int unsigned STAT_ADDR = 7'h11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dm_rst,
   input  logic              auth_wr,
   input  logic              auth_rd,
   input  logic [DATA_W-1:0] auth_wdata,
   output logic [DATA_W-1:0] auth_rdata,
   output logic              authenticated,
   output logic              auth_busy,
   output logic [DATA_W-1:0] stat_word,
   input  logic              dmi_req,
   input  logic [ADDR_W-1:0] dmi_addr,
   output logic              dmi_pass,
   input  logic              halt_req_i,
   output logic              halt_req_o,
   input  logic              resume_req_i,
   output logic              resume_req_o
);
   import dbg_auth_pkg::*;

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   generate
      if (DATA_W != AUTH_DATA_W) begin : g_bad_width
         $error("dbg_auth_gate: DATA_W must be 32");
      end
      if (AUTH_ADDR >= ADDR_SPAN || STAT_ADDR >= ADDR_SPAN) begin : g_bad_addr
         $error("dbg_auth_gate: register address outside ADDR_W range");
      end
      if (AUTH_ADDR == STAT_ADDR) begin : g_same_addr
         $error("dbg_auth_gate: data and status addresses must differ");
      end
   endgenerate

   logic flag_w;
   logic busy_w;

   dbg_auth_store #(.AUTH_EN(AUTH_EN), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .dm_rst(dm_rst),
      .wr    (auth_wr),
      .rd    (auth_rd),
      .wdata (auth_wdata),
      .rdata (auth_rdata),
      .flag  (flag_w),
      .busy  (busy_w)
   );

   dbg_auth_stat #(.LEGACY(LEGACY), .DATA_W(DATA_W)) u_stat (
      .flag(flag_w),
      .busy(busy_w),
      .word(stat_word)
   );

   dbg_auth_filter #(.ADDR_W(ADDR_W), .AUTH_ADDR(AUTH_ADDR), .STAT_ADDR(STAT_ADDR)) u_filter (
      .flag    (flag_w),
      .req     (dmi_req),
      .addr    (dmi_addr),
      .halt_i  (halt_req_i),
      .resume_i(resume_req_i),
      .pass    (dmi_pass),
      .halt_o  (halt_req_o),
      .resume_o(resume_req_o)
   );

   assign authenticated = flag_w;
   assign auth_busy     = busy_w;
endmodule

// File: rtl/dbg_auth_chk.sv
module dbg_auth_chk #(
   parameter bit          AUTH_EN = 1'b1,
   parameter int unsigned DATA_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dm_rst,
   input logic              auth_wr,
   input logic              auth_rd,
   input logic [DATA_W-1:0] auth_wdata,
   input logic [DATA_W-1:0] auth_rdata,
   input logic              authenticated,
   input logic              auth_busy,
   input logic [DATA_W-1:0] stat_word,
   input logic              halt_req_o,
   input logic              resume_req_o
);
   localparam bit REAL = AUTH_EN;

   p_wr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (REAL && auth_wr && !dm_rst && auth_wdata[0]) |=> authenticated);

   p_wr_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (REAL && auth_wr && !dm_rst && !auth_wdata[0]) |=> !authenticated);

   p_rd_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !auth_rd |-> (auth_rdata == '0));

   p_dmrst_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (REAL && dm_rst) |=> !authenticated);

   p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !auth_busy);

   p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !authenticated |-> (!halt_req_o && !resume_req_o));

   p_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_word[7] == authenticated);

   p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !REAL |-> (authenticated && auth_rdata == '0));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (REAL && !auth_wr && !dm_rst) |=> $stable(authenticated));
endmodule

bind dbg_auth_gate dbg_auth_chk #(.AUTH_EN(AUTH_EN), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .dm_rst       (dm_rst),
   .auth_wr      (auth_wr),
   .auth_rd      (auth_rd),
   .auth_wdata   (auth_wdata),
   .auth_rdata   (auth_rdata),
   .authenticated(authenticated),
   .auth_busy    (auth_busy),
   .stat_word    (stat_word),
   .halt_req_o   (halt_req_o),
   .resume_req_o (resume_req_o)
);

// File: tb/tb_dbg_auth_gate.sv
`timescale 1ns/1ps
module tb_dbg_auth_gate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dm_rst = 1'b0;
   logic        auth_wr = 1'b0;
   logic        auth_rd = 1'b0;
   logic [31:0] auth_wdata = '0;
   logic        dmi_req = 1'b0;
   logic [6:0]  dmi_addr = '0;
   logic        halt_req_i = 1'b0;
   logic        resume_req_i = 1'b0;

   logic [31:0] rdata_a, stat_a, rdata_b, stat_b;
   logic        auth_a, busy_a, pass_a, halt_a, res_a;
   logic        auth_b, busy_b, pass_b, halt_b, res_b;

   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dbg_auth_gate dut (
      .clk(clk), .rst_n(rst_n), .dm_rst(dm_rst), .auth_wr(auth_wr), .auth_rd(auth_rd),
      .auth_wdata(auth_wdata), .auth_rdata(rdata_a), .authenticated(auth_a),
      .auth_busy(busy_a), .stat_word(stat_a), .dmi_req(dmi_req), .dmi_addr(dmi_addr),
      .dmi_pass(pass_a), .halt_req_i(halt_req_i), .halt_req_o(halt_a),
      .resume_req_i(resume_req_i), .resume_req_o(res_a)
   );

   dbg_auth_gate #(.AUTH_EN(1'b0), .LEGACY(1'b1)) dut_byp (
      .clk(clk), .rst_n(rst_n), .dm_rst(dm_rst), .auth_wr(auth_wr), .auth_rd(auth_rd),
      .auth_wdata(auth_wdata), .auth_rdata(rdata_b), .authenticated(auth_b),
      .auth_busy(busy_b), .stat_word(stat_b), .dmi_req(dmi_req), .dmi_addr(dmi_addr),
      .dmi_pass(pass_b), .halt_req_i(halt_req_i), .halt_req_o(halt_b),
      .resume_req_i(resume_req_i), .resume_req_o(res_b)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_cycle(input logic [31:0] v, input logic rst_too);
      @(negedge clk);
      auth_wr = 1'b1; auth_wdata = v; dm_rst = rst_too;
      @(negedge clk);
      auth_wr = 1'b0; auth_wdata = '0; dm_rst = 1'b0;
      #1;
   endtask

   task automatic t_reset;
      #1;
      chk("R1 auth after reset", {31'b0, auth_a}, 32'd0);
      chk("R6 busy after reset", {31'b0, busy_a}, 32'd0);
      chk("R8 status unauthenticated", stat_a, 32'h0000_0003);
   endtask

   task automatic t_set;
      wr_cycle(32'h0000_0001, 1'b0);
      chk("R2 set by 0x1", {31'b0, auth_a}, 32'd1);
      chk("R8 status authenticated", stat_a, 32'h0000_0083);
      wr_cycle(32'hFFFF_FFFE, 1'b0);
      chk("R3 clear with upper bits set", {31'b0, auth_a}, 32'd0);
      wr_cycle(32'h8000_0003, 1'b0);
      chk("R2 set with upper bits", {31'b0, auth_a}, 32'd1);
      chk("R6 busy after write", {31'b0, busy_a}, 32'd0);
   endtask

   task automatic t_read;
      @(negedge clk); auth_rd = 1'b1; #1;
      chk("R4 read while set", rdata_a, 32'd1);
      auth_rd = 1'b0; #1;
      chk("R4 no read strobe", rdata_a, 32'd0);
   endtask

   task automatic t_hold;
      @(negedge clk); auth_rd = 1'b1;
      repeat (3) @(negedge clk);
      auth_rd = 1'b0; #1;
      chk("R10 held across reads", {31'b0, auth_a}, 32'd1);
   endtask

   task automatic t_gate_open;
      dmi_req = 1'b1; dmi_addr = 7'h17; halt_req_i = 1'b1; resume_req_i = 1'b1; #1;
      chk("R7 open pass", {31'b0, pass_a}, 32'd1);
      chk("R7 open halt/resume", {30'b0, halt_a, res_a}, 32'd3);
      dmi_req = 1'b0; halt_req_i = 1'b0; resume_req_i = 1'b0; #1;
      chk("R7 open idle", {29'b0, pass_a, halt_a, res_a}, 32'd0);
   endtask

   task automatic t_dmrst;
      wr_cycle(32'h0000_0001, 1'b1);
      chk("R5 dm reset beats write", {31'b0, auth_a}, 32'd0);
      wr_cycle(32'h0000_0001, 1'b0);
      @(negedge clk); dm_rst = 1'b1;
      @(negedge clk); dm_rst = 1'b0; #1;
      chk("R5 dm reset clears", {31'b0, auth_a}, 32'd0);
      @(negedge clk); auth_rd = 1'b1; #1;
      chk("R4 read while clear", rdata_a, 32'd0);
      auth_rd = 1'b0;
   endtask

   task automatic t_gate_closed;
      halt_req_i = 1'b1; resume_req_i = 1'b1; dmi_req = 1'b1;
      dmi_addr = 7'h17; #1;
      chk("R7 command blocked", {29'b0, pass_a, halt_a, res_a}, 32'd0);
      dmi_addr = 7'h30; #1;
      chk("R7 data reg passes", {29'b0, pass_a, halt_a, res_a}, 32'd4);
      dmi_addr = 7'h11; #1;
      chk("R7 status reg passes", {29'b0, pass_a, halt_a, res_a}, 32'd4);
      dmi_addr = 7'h10; #1;
      chk("R7 control reg blocked", {31'b0, pass_a}, 32'd0);
      dmi_req = 1'b0; dmi_addr = 7'h30; #1;
      chk("R7 no request no pass", {31'b0, pass_a}, 32'd0);
      halt_req_i = 1'b0; resume_req_i = 1'b0;
   endtask

   task automatic t_bypass;
      chk("R9 bypass auth", {31'b0, auth_b}, 32'd1);
      chk("R8 legacy status", stat_b, 32'h0000_0082);
      wr_cycle(32'h0000_0000, 1'b1);
      chk("R9 bypass ignores write/reset", {30'b0, auth_b, busy_b}, 32'd2);
      @(negedge clk); auth_rd = 1'b1; #1;
      chk("R9 bypass rdata", rdata_b, 32'd0);
      auth_rd = 1'b0;
      dmi_req = 1'b1; dmi_addr = 7'h17; halt_req_i = 1'b1; resume_req_i = 1'b1; #1;
      chk("R9 bypass gate open", {29'b0, pass_b, halt_b, res_b}, 32'd7);
      dmi_req = 1'b0; halt_req_i = 1'b0; resume_req_i = 1'b0;
   endtask

   task automatic t_sysreset;
      wr_cycle(32'h0000_0001, 1'b0);
      @(negedge clk); rst_n = 1'b0; #1;
      chk("R1 async reset clears", {31'b0, auth_a}, 32'd0);
      @(negedge clk); rst_n = 1'b1; #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_set();
      t_read();
      t_hold();
      t_gate_open();
      t_dmrst();
      t_gate_closed();
      t_bypass();
      t_sysreset();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nvec++; nbad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end
endmodule